// File: doc/BRIEF.md
# Dual-Bank Indexed CMOS RAM Port

This block sits on a simple host I/O bus and gives access to two 128-byte banks of battery-backed RAM. Each bank is reached through its own pair of ports: an index port that selects a byte, and a data port that reads or writes the selected byte. Every port of the eight-port window also answers at a second, alias address. In the standard bank, the 14 lowest bytes hold the clock, calendar and configuration registers used by timekeeping logic elsewhere. The remaining 114 bytes are free user storage. The extended bank is plain RAM over its full range and is always enabled.

The primary standard index port has one extra job. Bit 7 of a write to that port is kept as an NMI-enable control and is driven on a side output. A write to the alias of that port changes only the index, so software can move the pointer without touching NMI gating.

Reads return data combinationally while the read strobe is high. Writes take effect on the rising clock edge. Reset clears both indices and the NMI-enable bit. RAM contents are not reset.

Top module: `cmos_ram_port`

## Requirements
- R1: While reset is asserted, and directly after it, nmi_en is 0 and reads of both index ports (70h and 72h) return 00h.
- R2: A write to port 70h loads data bit 7 into nmi_en and data bits 6:0 into the standard index. A read of 70h or 74h returns {1'b0, standard index}.
- R3: A write to port 74h loads data bits 6:0 into the standard index and leaves nmi_en unchanged. nmi_en changes only on a write to 70h or on reset.
- R4: A write to port 72h or 76h loads data bits 6:0 into the extended index and drops bit 7. A read of 72h or 76h returns {1'b0, extended index}.
- R5: A write to port 71h or 75h stores the data byte at the standard-bank location given by the standard index. A read of either port returns that byte.
- R6: A write to port 73h or 77h stores the data byte at the extended-bank location given by the extended index. A read of either port returns that byte.
- R7: The two banks are separate storage. A write into one bank never changes the other, even when both indices hold the same value.
- R8: Data-port accesses do not change the index. Back-to-back writes go to the same byte, and the last write wins.
- R9: A read of any port outside 70h–77h returns FFh. A write outside that range changes no index, no RAM byte and not nmi_en.
- R10: RAM contents in both banks survive a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; FFh when io_rd is low or the port is undecoded |
| nmi_en | output | 1 | Captured NMI-enable bit |

## Verification
The bench works on the spots where address decode is easy to get wrong. An alias write to 74h must leave nmi_en alone; a design that treats 74h exactly like 70h would clear or set nmi_en. Bit 7 written to the extended index port must be dropped; keeping it would put the index out of range or break the readback. Both banks are loaded with the same index value; shared storage or a wrong bank select would let one bank's data show through the other. The bench also repeats writes to one data port, writes and reads outside the window, and reads RAM after a reset. These catch auto-increment, side effects of undecoded writes, and a RAM that is wrongly reset.

// File: rtl/cmos_ram_port.sv
module cmos_ram_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 7,
  parameter logic [ADDR_W-1:0] BASE_PORT = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              nmi_en
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] std_idx, ext_idx;
  logic [DATA_W-1:0] std_mem [DEPTH];
  logic [DATA_W-1:0] ext_mem [DEPTH];

  wire in_win   = io_addr[ADDR_W-1:3] == BASE_PORT[ADDR_W-1:3];
  wire is_alias = io_addr[2];
  wire sel_sidx = in_win && io_addr[1:0] == 2'd0;
  wire sel_sdat = in_win && io_addr[1:0] == 2'd1;
  wire sel_eidx = in_win && io_addr[1:0] == 2'd2;
  wire sel_edat = in_win && io_addr[1:0] == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_idx <= '0;
      ext_idx <= '0;
      nmi_en  <= 1'b0;
    end else if (io_wr) begin
      if (sel_sidx) begin
        std_idx <= io_wdata[IDX_W-1:0];
        if (!is_alias) nmi_en <= io_wdata[DATA_W-1];
      end
      if (sel_eidx) ext_idx <= io_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (io_wr && sel_sdat) std_mem[std_idx] <= io_wdata;
    if (io_wr && sel_edat) ext_mem[ext_idx] <= io_wdata;
  end

  always_comb begin
    io_rdata = '1;
    if (io_rd) begin
      if (sel_sidx) io_rdata = {{(DATA_W-IDX_W){1'b0}}, std_idx};
      if (sel_sdat) io_rdata = std_mem[std_idx];
      if (sel_eidx) io_rdata = {{(DATA_W-IDX_W){1'b0}}, ext_idx};
      if (sel_edat) io_rdata = ext_mem[ext_idx];
    end
  end
endmodule

module cmos_ram_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_addr,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       nmi_en
);
  wire win = io_addr[7:3] == 5'b01110;

  assert_nmi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h70) |=> nmi_en == $past(io_wdata[7]));

  assert_nmi_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h74) |=> $stable(nmi_en));

  assert_nmi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == 8'h70) |=> $stable(nmi_en));

  assert_idx_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && win && !io_addr[0]) |-> io_rdata[7] == 1'b0);

  assert_undecoded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !win) |-> io_rdata == 8'hFF);
endmodule

bind cmos_ram_port cmos_ram_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .nmi_en(nmi_en)
);

// File: tb/sim_cmos_ram_port.sv
module sim_cmos_ram_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  // {req[3:0], is_read, addr[7:0], wdata[7:0], expect[7:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2,  1'b0, 8'h70, 8'h85, 8'h00},  // R2 nmi=1, idx=05
    {4'd2,  1'b1, 8'h70, 8'h00, 8'h05},  // R2
    {4'd5,  1'b0, 8'h71, 8'hA1, 8'h00},  // R5
    {4'd5,  1'b1, 8'h71, 8'h00, 8'hA1},  // R5
    {4'd5,  1'b1, 8'h75, 8'h00, 8'hA1},  // R5 alias
    {4'd4,  1'b0, 8'h76, 8'h05, 8'h00},  // R4
    {4'd6,  1'b0, 8'h73, 8'h5C, 8'h00},  // R6
    {4'd6,  1'b1, 8'h77, 8'h00, 8'h5C},  // R6 alias
    {4'd7,  1'b1, 8'h71, 8'h00, 8'hA1},  // R7 same index, other bank
    {4'd3,  1'b0, 8'h74, 8'h0E, 8'h00},  // R3 index only
    {4'd2,  1'b1, 8'h74, 8'h00, 8'h0E},  // R2 alias read
    {4'd8,  1'b0, 8'h75, 8'h33, 8'h00},  // R8
    {4'd8,  1'b0, 8'h75, 8'h44, 8'h00},  // R8
    {4'd8,  1'b1, 8'h71, 8'h00, 8'h44},  // R8 last write wins
    {4'd8,  1'b1, 8'h70, 8'h00, 8'h0E},  // R8 index unchanged
    {4'd4,  1'b0, 8'h72, 8'hFF, 8'h00},  // R4 bit 7 dropped
    {4'd4,  1'b1, 8'h72, 8'h00, 8'h7F},  // R4
    {4'd6,  1'b0, 8'h73, 8'h99, 8'h00},  // R6
    {4'd6,  1'b1, 8'h73, 8'h00, 8'h99},  // R6
    {4'd9,  1'b0, 8'h40, 8'h12, 8'h00},  // R9 undecoded write
    {4'd9,  1'b1, 8'h40, 8'h00, 8'hFF},  // R9
    {4'd9,  1'b1, 8'h78, 8'h00, 8'hFF},  // R9
    {4'd9,  1'b1, 8'h71, 8'h00, 8'h44},  // R9 no side effect
    {4'd4,  1'b1, 8'h76, 8'h00, 8'h7F}   // R4 alias read
  };

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic nmi_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmos_ram_port u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .nmi_en(nmi_en));

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check(1, {7'd0, nmi_en}, 8'h00);           // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) begin
        rd(VEC[i][23:16], r);
        check(int'(VEC[i][28:25]), r, VEC[i][7:0]);
      end else wr(VEC[i][23:16], VEC[i][15:8]);
    end
    check(3, {7'd0, nmi_en}, 8'h01);           // R3 alias kept nmi_en=1
    wr(8'h70, 8'h0E);
    check(2, {7'd0, nmi_en}, 8'h00);           // R2 clears nmi_en
    wr(8'h74, 8'h80);
    check(3, {7'd0, nmi_en}, 8'h00);           // R3 alias bit 7 ignored
    rd(8'h70, r); check(3, r, 8'h00);
    wr(8'h70, 8'h8E);
    wr(8'h40, 8'h00);
    check(9, {7'd0, nmi_en}, 8'h01);           // R9 undecoded write leaves nmi
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(1, {7'd0, nmi_en}, 8'h00);           // R1
    rst_n = 1'b1;
    rd(8'h70, r); check(1, r, 8'h00);          // R1
    rd(8'h72, r); check(1, r, 8'h00);          // R1
    wr(8'h70, 8'h0E);
    rd(8'h71, r); check(10, r, 8'h44);         // R10 standard bank kept
    wr(8'h72, 8'h7F);
    rd(8'h73, r); check(10, r, 8'h99);         // R10 extended bank kept
    wr(8'h76, 8'h05);
    rd(8'h73, r); check(7, r, 8'h5C);          // R7
    rd(8'h20, r); check(9, r, 8'hFF);          // R9
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule